// File: doc/BRIEF.md
# YCbCr 4:2:0 Two-Pixel Packer

This block accepts one YCbCr 4:2:2 pixel per clock: a luma sample and a chroma sample that alternates between Cb and Cr from pixel to pixel. Alongside the pixels it receives a data enable and horizontal and vertical sync. In 4:2:0 mode it combines each pair of horizontally adjacent pixels into one 48-bit word, so words come out at half the input pixel rate. It keeps the blue-difference chroma on even lines and the red-difference chroma on odd lines. The half-rate output is marked by a one-cycle valid strobe that the downstream logic uses as a clock enable. In bypass mode the same 48-bit layout carries 4:2:2 data at full rate. Components narrower than 16 bits are left-justified in 16-bit fields.

The controller is a three-state machine:
- `ST_BYPASS` is the 4:2:2 pass-through.
- `ST_WAIT_EVEN` waits for the even pixel of a pair and latches it.
- `ST_HOLD_EVEN` holds that pixel until the odd pixel arrives, or until the line ends.

The transitions are:
- *pair-open* (`ST_WAIT_EVEN` to `ST_HOLD_EVEN`, taken on an active pixel).
- *pair-close* (`ST_HOLD_EVEN` to `ST_WAIT_EVEN`, taken every cycle, which emits a word).
- *frame-select* (any state to `ST_BYPASS` or `ST_WAIT_EVEN` on the rising edge of vertical sync, chosen by the mode input).

A separate tracker keeps the line parity.

Top module: `ycc420_pair_packer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid`, `out_de`, `out_hsync`, `out_vsync` and `out_word` are all zero, and the block is in bypass mode.
- R2: `mode_420` (1 = 4:2:0 packing, 0 = 4:2:2 bypass) takes effect only in a cycle where `in_vsync` rises. Changes on `mode_420` at any other time have no effect on the output.
- R3: In bypass mode, one cycle after each input cycle, `out_word` = {16'h0, Y field, C field} and `out_valid` equals the previous cycle's `in_de`.
- R4: In 4:2:0 mode, the active pixels of a line are paired as (0,1), (2,3), and so on. One cycle after the odd pixel of a pair, `out_valid` pulses for exactly one cycle with `out_word[47:32]` = Y of the odd pixel and `out_word[31:16]` = Y of the even pixel. `out_valid` is never high in two consecutive cycles.
- R5: In 4:2:0 mode, `out_word[15:0]` holds the chroma sample that entered with the even pixel (Cb) on even lines. On odd lines it holds the chroma sample that entered with the odd pixel (Cr).
- R6: The first line after a rising edge of `in_vsync` is line 0, which is even. Parity toggles on every falling edge of `in_de`. If `in_vsync` rises in the same cycle that `in_de` falls, the parity is set to even.
- R7: If a line ends on an unpaired pixel, a word is emitted one cycle after `in_de` falls. In that word `[47:32]` is zero and `[31:16]` is the last Y. `[15:0]` is that pixel's Cb on an even line and zero on an odd line.
- R8: Pairing restarts at each line, so the first active pixel after a rising edge of `in_de` is always the even pixel of a pair.
- R9: `out_hsync` and `out_vsync` equal `in_hsync` and `in_vsync` delayed by one cycle, and `out_de` equals `out_valid` in every cycle.
- R10: A COMP_W-bit component occupies the top COMP_W bits of its 16-bit field, and the low bits are zero (with COMP_W = 12, 12'hABC becomes 16'hABC0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_420 | input | 1 | 1 = 4:2:0 packing, 0 = 4:2:2 bypass; sampled on the rising edge of vertical sync |
| in_de | input | 1 | Active-video enable |
| in_hsync | input | 1 | Horizontal sync |
| in_vsync | input | 1 | Vertical sync |
| in_y | input | COMP_W | Luma sample |
| in_c | input | COMP_W | Chroma sample, alternating Cb/Cr |
| out_word | output | 3*FIELD_W | Packed output word |
| out_valid | output | 1 | Word strobe / clock enable |
| out_de | output | 1 | Output enable, equal to the strobe |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |

## Verification
Two events can share a cycle, and each has its own test.

The first is the falling edge of the enable coinciding with a rising edge of vertical sync. The bench provokes this at the end of an odd line. The check is that the flushed word still carries the finished line's parity, and that the first line of the new frame takes Cb.

The second is an odd-width line, where the flush of the unpaired pixel lands in the same cycle as the parity toggle. The check is that the flush word uses the parity of the line that just ended, on both an even line and an odd line.

A behavioural model in the bench is compared against every output on every clock.

// File: rtl/ypk_pkg.sv
package ypk_pkg;
    typedef enum logic [1:0] {
        ST_BYPASS    = 2'd0,
        ST_WAIT_EVEN = 2'd1,
        ST_HOLD_EVEN = 2'd2
    } pk_state_e;
endpackage

// File: rtl/ypk_msb_align.sv
module ypk_msb_align #(
    parameter int COMP_W  = 12,
    parameter int FIELD_W = 16
) (
    input  logic [COMP_W-1:0]  comp_i,
    output logic [FIELD_W-1:0] field_o
);
    localparam int PAD_W = FIELD_W - COMP_W;

    generate
        if (PAD_W == 0) begin : g_full
            assign field_o = comp_i;
        end else begin : g_pad
            // left-justify, zero fill below
            assign field_o = {comp_i, {PAD_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/ypk_line_parity.sv
module ypk_line_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic de_i,
    input  logic vsync_i,
    output logic frame_start_o,
    output logic line_odd_o
);
    logic de_q;
    logic vs_q;
    logic de_fall;

    assign frame_start_o = vsync_i && !vs_q;
    assign de_fall       = de_q && !de_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q       <= 1'b0;
            vs_q       <= 1'b0;
            line_odd_o <= 1'b0;
        end else begin
            de_q <= de_i;
            vs_q <= vsync_i;
            if (frame_start_o)
                line_odd_o <= 1'b0;       // frame start wins over a coincident line end
            else if (de_fall)
                line_odd_o <= ~line_odd_o;
        end
    end

    a_r6_even_after_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !line_odd_o);

    a_r6_toggle_on_de_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (de_fall && !frame_start_o) |=> (line_odd_o != $past(line_odd_o)));

    a_r6_steady_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (!de_fall && !frame_start_o) |=> $stable(line_odd_o));
endmodule

// File: rtl/ypk_pair_fsm.sv
module ypk_pair_fsm
    import ypk_pkg::*;
#(
    parameter int FIELD_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start_i,
    input  logic                   mode_420_i,
    input  logic                   line_odd_i,
    input  logic                   de_i,
    input  logic                   hsync_i,
    input  logic                   vsync_i,
    input  logic [FIELD_W-1:0]     y_i,
    input  logic [FIELD_W-1:0]     c_i,
    output logic [3*FIELD_W-1:0]   word_o,
    output logic                   valid_o,
    output logic                   hsync_o,
    output logic                   vsync_o
);
    localparam int WORD_W = 3 * FIELD_W;
    localparam logic [FIELD_W-1:0] ZERO_F = '0;

    pk_state_e state_q, state_d;
    logic [FIELD_W-1:0] y_hold;
    logic [FIELD_W-1:0] c_hold;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BYPASS;
        else        state_q <= state_d;
    end

    // next state: frame-select, pair-open, pair-close
    always_comb begin
        state_d = state_q;
        if (frame_start_i) begin
            state_d = mode_420_i ? ST_WAIT_EVEN : ST_BYPASS;
        end else begin
            unique case (state_q)
                ST_BYPASS:    state_d = ST_BYPASS;
                ST_WAIT_EVEN: if (de_i) state_d = ST_HOLD_EVEN;
                ST_HOLD_EVEN: state_d = ST_WAIT_EVEN;
                default:      state_d = ST_BYPASS;
            endcase
        end
    end

    // outputs and pixel hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            y_hold  <= '0;
            c_hold  <= '0;
        end else begin
            hsync_o <= hsync_i;
            vsync_o <= vsync_i;
            unique case (state_q)
                ST_BYPASS: begin
                    valid_o <= de_i;
                    word_o  <= {ZERO_F, y_i, c_i};
                end
                ST_WAIT_EVEN: begin
                    valid_o <= 1'b0;
                    if (de_i) begin
                        y_hold <= y_i;
                        c_hold <= c_i;
                    end
                end
                ST_HOLD_EVEN: begin
                    valid_o <= 1'b1;
                    if (de_i)
                        word_o <= {y_i, y_hold, line_odd_i ? c_i : c_hold};
                    else
                        word_o <= {ZERO_F, y_hold, line_odd_i ? ZERO_F : c_hold};
                end
                default: valid_o <= 1'b0;
            endcase
        end
    end

    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && state_q == ST_WAIT_EVEN) |=> !valid_o);

    a_r2_bypass_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start_i && state_q == ST_BYPASS) |=> (state_q == ST_BYPASS));

    a_r2_packing_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start_i && state_q != ST_BYPASS) |=> (state_q != ST_BYPASS));

    a_r3_bypass_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYPASS) |=> (word_o[WORD_W-1 -: FIELD_W] == ZERO_F));

    a_r7_flush_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_EVEN && !de_i) |=> (valid_o && word_o[WORD_W-1 -: FIELD_W] == ZERO_F));
endmodule

// File: rtl/ycc420_pair_packer.sv
module ycc420_pair_packer #(
    parameter int COMP_W  = 12,
    parameter int FIELD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_420,
    input  logic                  in_de,
    input  logic                  in_hsync,
    input  logic                  in_vsync,
    input  logic [COMP_W-1:0]     in_y,
    input  logic [COMP_W-1:0]     in_c,
    output logic [3*FIELD_W-1:0]  out_word,
    output logic                  out_valid,
    output logic                  out_de,
    output logic                  out_hsync,
    output logic                  out_vsync
);
    logic [FIELD_W-1:0] y_field;
    logic [FIELD_W-1:0] c_field;
    logic               frame_start;
    logic               line_odd;

    ypk_msb_align #(.COMP_W(COMP_W), .FIELD_W(FIELD_W)) u_align_y (
        .comp_i (in_y),
        .field_o(y_field)
    );

    ypk_msb_align #(.COMP_W(COMP_W), .FIELD_W(FIELD_W)) u_align_c (
        .comp_i (in_c),
        .field_o(c_field)
    );

    ypk_line_parity u_parity (
        .clk          (clk),
        .rst_n        (rst_n),
        .de_i         (in_de),
        .vsync_i      (in_vsync),
        .frame_start_o(frame_start),
        .line_odd_o   (line_odd)
    );

    ypk_pair_fsm #(.FIELD_W(FIELD_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start),
        .mode_420_i   (mode_420),
        .line_odd_i   (line_odd),
        .de_i         (in_de),
        .hsync_i      (in_hsync),
        .vsync_i      (in_vsync),
        .y_i          (y_field),
        .c_i          (c_field),
        .word_o       (out_word),
        .valid_o      (out_valid),
        .hsync_o      (out_hsync),
        .vsync_o      (out_vsync)
    );

    assign out_de = out_valid;
endmodule

// File: tb/test_ycc420_pair_packer.sv
module test_ycc420_pair_packer;
    localparam int CW = 12;
    localparam int FW = 16;
    localparam int WW = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          in_mode = 1'b0;
    logic          in_de = 1'b0;
    logic          in_hsync = 1'b0;
    logic          in_vsync = 1'b0;
    logic [CW-1:0] in_y = '0;
    logic [CW-1:0] in_c = '0;
    logic [WW-1:0] out_word;
    logic          out_valid, out_de, out_hsync, out_vsync;

    ycc420_pair_packer i_ycc420_pair_packer (
        .clk(clk), .rst_n(rst_n), .mode_420(in_mode),
        .in_de(in_de), .in_hsync(in_hsync), .in_vsync(in_vsync),
        .in_y(in_y), .in_c(in_c),
        .out_word(out_word), .out_valid(out_valid), .out_de(out_de),
        .out_hsync(out_hsync), .out_vsync(out_vsync)
    );

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";

    // expected outputs after the next edge
    logic [WW-1:0] e_word = '0;
    logic          e_valid = 1'b0, e_hs = 1'b0, e_vs = 1'b0;
    // reference model state
    bit            m_mode = 1'b0, m_odd = 1'b0, m_pde = 1'b0, m_pvs = 1'b0;
    int            m_idx = 0;
    logic [FW-1:0] m_hy = '0, m_hc = '0;

    function automatic logic [FW-1:0] al(logic [CW-1:0] v);
        return {v, 4'h0};
    endfunction

    task automatic chk_w(string what, logic [WW-1:0] act, logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_b(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk_b("valid", out_valid, e_valid);
        chk_b("de", out_de, e_valid);
        chk_b("hsync", out_hsync, e_hs);
        chk_b("vsync", out_vsync, e_vs);
        if (e_valid) chk_w("word", out_word, e_word);
    endtask

    task automatic model();
        bit frame, fell;
        frame = in_vsync && !m_pvs;
        fell  = m_pde && !in_de;
        e_hs  = in_hsync;
        e_vs  = in_vsync;
        if (m_mode) begin
            e_valid = 1'b0;
            if (in_de) begin
                if (m_idx % 2 == 0) begin
                    m_hy = al(in_y);
                    m_hc = al(in_c);
                end else begin
                    e_valid = 1'b1;
                    e_word  = {al(in_y), m_hy, m_odd ? al(in_c) : m_hc};
                end
                m_idx++;
            end else begin
                if (fell && (m_idx % 2 == 1)) begin
                    e_valid = 1'b1;
                    e_word  = {16'h0, m_hy, m_odd ? 16'h0 : m_hc};
                end
                m_idx = 0;
            end
        end else begin
            e_valid = in_de;
            e_word  = {16'h0, al(in_y), al(in_c)};
        end
        if (frame) begin
            m_odd  = 1'b0;
            m_mode = in_mode;
            m_idx  = 0;
        end else if (fell) begin
            m_odd = !m_odd;
        end
        m_pde = in_de;
        m_pvs = in_vsync;
    endtask

    task automatic cyc(bit de, bit hs, bit vs, logic [CW-1:0] y, logic [CW-1:0] c);
        @(negedge clk);
        compare();
        in_de = de; in_hsync = hs; in_vsync = vs; in_y = y; in_c = c;
        model();
    endtask

    // one line: hsync, blank, active pixels, trailing blank (optionally with vsync)
    task automatic line(int width, int base, bit vs_end);
        cyc(1'b0, 1'b1, 1'b0, '0, '0);
        cyc(1'b0, 1'b0, 1'b0, '0, '0);
        for (int i = 0; i < width; i++)
            cyc(1'b1, 1'b0, 1'b0, CW'(base + i), (i % 2 == 0) ? CW'(12'hB00 + i) : CW'(12'hC00 + i));
        cyc(1'b0, 1'b0, vs_end, '0, '0);
        cyc(1'b0, 1'b0, vs_end, '0, '0);
        cyc(1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic vsync_pulse(bit mode);
        in_mode = mode;
        cyc(1'b0, 1'b0, 1'b1, '0, '0);
        cyc(1'b0, 1'b0, 1'b1, '0, '0);
        cyc(1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        compare();
        chk_w("word at reset", out_word, '0);
        rst_n = 1'b1;

        // R3, R9: bypass layout and sync delay
        tag = "R3 R9";
        vsync_pulse(1'b0);
        line(4, 'h100, 1'b0);
        line(3, 'h180, 1'b0);

        // R10: left justification of narrow components
        tag = "R10";
        cyc(1'b1, 1'b0, 1'b0, 12'hABC, 12'h5A5);
        cyc(1'b0, 1'b0, 1'b0, '0, '0);
        chk_w("aligned word", out_word, 48'h0000_ABC0_5A50);

        // R2: mode change mid-frame ignored
        tag = "R2";
        in_mode = 1'b1;
        line(4, 'h200, 1'b0);

        // R4, R5: packing on even then odd lines
        tag = "R4 R5";
        vsync_pulse(1'b1);
        line(6, 'h300, 1'b0);
        tag = "R5 R6";
        line(6, 'h400, 1'b0);

        // R7: unpaired trailing pixel on even and odd lines
        tag = "R7";
        line(5, 'h500, 1'b0);
        line(3, 'h600, 1'b0);

        // R8: pairing restarts after an odd-width line
        tag = "R8";
        line(4, 'h700, 1'b0);

        // R2: mode drop mid-frame ignored while packing
        tag = "R2";
        in_mode = 1'b0;
        line(4, 'h800, 1'b0);

        // R6: vsync rise in the same cycle as the enable falls on an odd line
        tag = "R6";
        in_mode = 1'b1;
        line(4, 'h900, 1'b0);
        line(5, 'hA00, 1'b1);
        line(4, 'hB00, 1'b0);
        line(2, 'hB80, 1'b0);

        // R2: return to bypass at the next frame
        tag = "R2 R3";
        vsync_pulse(1'b0);
        line(3, 'hC00, 1'b0);

        cyc(1'b0, 1'b0, 1'b0, '0, '0);
        summary();
        $finish;
    end
endmodule